// File: doc/BRIEF.md
# Hitless Reference Switch Phase Compensator

This block sits in a timing loop that can follow either of two reference clocks. It sits between the reference selector and the loop's phase detector. When the selection moves from one reference to the other, the new reference usually arrives at a different phase than the old one. If that edge went straight to the detector, the loop would see a phase step and slew the output toward it. Instead, at the first edge of the new reference, the block measures how far that edge lies from the most recent feedback edge. It folds this time-interval error into a stored offset and from then on delays every selected reference edge by that offset. The loop therefore sees a virtual reference that stays where the previous one was.

Time is counted in system clock ticks and taken modulo the reference period `PERIOD`. The offset is applied by a down-counter that turns each selected edge into a one-cycle output strobe. Compensation is switched off when the enable input is low or the mode controller raises its auto-disable line. The controller does this after a short holdover, so that offsets do not pile up. While compensation is off, edges pass through unshifted, and the loop re-aligns to the reference that is actually selected. A filtered active-low clear input zeroes the stored offset.

The control state machine has three states:
- `ST_BYPASS`: compensation is off.
- `ST_TRACK`: compensation is on and edges are delayed by the stored offset.
- `ST_MEASURE`: a switch has been seen and the block waits for the first edge of the new reference.

It has these transitions:
- Any state goes to `ST_BYPASS` when compensation turns off.
- `ST_BYPASS` goes to `ST_TRACK` when compensation turns on.
- `ST_TRACK` goes to `ST_MEASURE` on a change of the select line.
- `ST_MEASURE` stays in `ST_MEASURE` on a further change of the select line.
- `ST_MEASURE` goes to `ST_TRACK` on the first selected edge, which completes the measurement.

Top module: `refsw_phase_comp`

## Requirements
- R1: After reset the stored offset is 0 and `vref_stb` is low.
- R2: The selected edge is `ref_a_stb` when `ref_sel` is 0 and `ref_b_stb` when `ref_sel` is 1. A strobe on the unselected input produces no output pulse and no measurement.
- R3: The first selected edge in a cycle strictly after a change of `ref_sel` completes a measurement, provided compensation is on. Let d be the number of cycles since the last `fb_stb`, taken modulo `PERIOD`; d is 0 when the two strobes coincide. The offset then becomes (offset + PERIOD − d) mod PERIOD. At no other time does the offset change, except through a clear.
- R4: With compensation on, a selected edge sampled at clock edge t gives a one-cycle `vref_stb` that rises at clock edge t + D. D is the offset held after edge t, so the edge that completes a measurement already uses the new value.
- R5: When `comp_en` is 0 or `auto_dis` is 1, every selected edge gives `vref_stb` at the very next clock edge (D = 0), no measurement happens, and the stored offset is kept.
- R6: Turning compensation off while a measurement is pending abandons that measurement. When compensation returns, edges use the kept offset and no new measurement occurs until the next change of `ref_sel`.
- R7: Once `clr_n` has been sampled low on `CLR_LOW_MIN` consecutive clock edges (30 by default, 300 ns at 100 MHz), the offset is 0 after that edge. It stays 0 while `clr_n` remains low. A shorter low interval leaves the offset unchanged.
- R8: When a clear and a completed measurement fall on the same clock edge, the clear wins: the offset becomes 0, and the measuring edge leaves with D = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_a_stb | input | 1 | One-cycle edge strobe of reference A |
| ref_b_stb | input | 1 | One-cycle edge strobe of reference B |
| ref_sel | input | 1 | Reference select, 0 = A, 1 = B |
| fb_stb | input | 1 | One-cycle edge strobe of the loop feedback |
| comp_en | input | 1 | Compensation enable, active high |
| auto_dis | input | 1 | Compensation disable from the mode controller, active high |
| clr_n | input | 1 | Active-low offset clear, filtered by a minimum low time |
| vref_stb | output | 1 | One-cycle strobe of the virtual reference |
| offset | output | $clog2(PERIOD) | Stored phase offset in system clock ticks |

## Verification
The clear filter reaching its threshold can land on the same clock edge as the first edge of a newly selected reference. In that case the offset register is written by both the clear and the measurement. The bench provokes this by holding `clr_n` low from the feedback strobe onward, so that the 30th low sample coincides with the measuring edge. Without the clear, that measurement would produce a nonzero offset. The outcome is judged by reading a zero offset and by seeing the strobe leave on the very next cycle. The normal measurement path is swept over every phase distance modulo the period, and each expected offset and strobe position is computed arithmetically.

// File: rtl/refsw_pkg.sv
package refsw_pkg;

    typedef enum logic [1:0] {
        ST_BYPASS  = 2'd0,
        ST_TRACK   = 2'd1,
        ST_MEASURE = 2'd2
    } refsw_state_e;

endpackage

// File: rtl/refsw_fb_phase.sv
// Cycles elapsed since the last feedback strobe, modulo the reference period.
module refsw_fb_phase #(
    parameter int PERIOD = 16,
    localparam int PW = $clog2(PERIOD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fb_stb,
    output logic [PW-1:0] phase
);

    logic [PW-1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (fb_stb) begin
            age_q <= PW'(1);
        end else if (age_q == PW'(PERIOD - 1)) begin
            age_q <= '0;
        end else begin
            age_q <= age_q + PW'(1);
        end
    end

    // A feedback edge in the current cycle means zero distance.
    assign phase = fb_stb ? '0 : age_q;

endmodule

// File: rtl/refsw_clr_filter.sv
// Qualifies the clear input: it fires only after a minimum run of low samples.
module refsw_clr_filter #(
    parameter int CLR_LOW_MIN = 30,
    localparam int CW = $clog2(CLR_LOW_MIN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_n,
    output logic hit
);

    logic [CW-1:0] low_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_q <= '0;
        end else if (clr_n) begin
            low_q <= '0;
        end else if (low_q != CW'(CLR_LOW_MIN)) begin
            low_q <= low_q + CW'(1);
        end
    end

    assign hit = !clr_n && (low_q >= CW'(CLR_LOW_MIN - 1));

endmodule

// File: rtl/refsw_edge_delay.sv
// Delays a trigger by a programmable number of cycles; a zero delay leaves
// one register stage, so every path has the same base latency.
module refsw_edge_delay #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         trig,
    input  logic [W-1:0] dly,
    output logic         pulse
);

    logic [W-1:0] cnt_q;
    logic         expire;
    logic         fire_now;

    assign expire   = (cnt_q == W'(1));
    assign fire_now = trig && (dly == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            pulse <= 1'b0;
        end else begin
            pulse <= expire || fire_now;
            if (trig && (dly != '0)) begin
                cnt_q <= dly;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - W'(1);
            end
        end
    end

endmodule

// File: rtl/refsw_phase_comp.sv
module refsw_phase_comp
    import refsw_pkg::*;
#(
    parameter int PERIOD      = 16,
    parameter int CLR_LOW_MIN = 30,
    localparam int PW = $clog2(PERIOD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_a_stb,
    input  logic          ref_b_stb,
    input  logic          ref_sel,
    input  logic          fb_stb,
    input  logic          comp_en,
    input  logic          auto_dis,
    input  logic          clr_n,
    output logic          vref_stb,
    output logic [PW-1:0] offset
);

    refsw_state_e  st;
    refsw_state_e  st_d;
    logic [PW-1:0] off_q;
    logic [PW-1:0] off_d;
    logic [PW-1:0] fb_phase;
    logic [PW-1:0] corr;
    logic [PW:0]   corr_w;
    logic [PW-1:0] dly;
    logic          sel_q;
    logic          sel_stb;
    logic          switch_now;
    logic          comp_on;
    logic          clr_hit;

    function automatic logic [PW-1:0] add_mod(input logic [PW-1:0] a,
                                              input logic [PW-1:0] b);
        logic [PW:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= (PW+1)'(PERIOD)) begin
            s = s - (PW+1)'(PERIOD);
        end
        return s[PW-1:0];
    endfunction

    assign sel_stb    = ref_sel ? ref_b_stb : ref_a_stb;
    assign switch_now = ref_sel ^ sel_q;
    assign comp_on    = comp_en && !auto_dis;

    refsw_fb_phase #(.PERIOD(PERIOD)) u_fb_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .fb_stb (fb_stb),
        .phase  (fb_phase)
    );

    refsw_clr_filter #(.CLR_LOW_MIN(CLR_LOW_MIN)) u_clr_filter (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_n (clr_n),
        .hit   (clr_hit)
    );

    // Correction that moves the new edge onto the next feedback edge.
    assign corr_w = (PW+1)'(PERIOD) - {1'b0, fb_phase};
    assign corr   = (fb_phase == '0) ? '0 : corr_w[PW-1:0];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= ST_BYPASS;
            off_q <= '0;
            sel_q <= 1'b0;
        end else begin
            st    <= st_d;
            off_q <= off_d;
            sel_q <= ref_sel;
        end
    end

    // Next state and offset
    always_comb begin
        st_d  = st;
        off_d = off_q;
        unique case (st)
            ST_BYPASS: begin
                if (comp_on) st_d = ST_TRACK;
            end
            ST_TRACK: begin
                if (!comp_on)        st_d = ST_BYPASS;
                else if (switch_now) st_d = ST_MEASURE;
            end
            ST_MEASURE: begin
                if (!comp_on) begin
                    st_d = ST_BYPASS;
                end else if (switch_now) begin
                    st_d = ST_MEASURE;
                end else if (sel_stb) begin
                    st_d  = ST_TRACK;
                    off_d = add_mod(off_q, corr);
                end
            end
            default: st_d = ST_BYPASS;
        endcase
        if (clr_hit) off_d = '0;
    end

    assign dly = comp_on ? off_d : '0;

    refsw_edge_delay #(.W(PW)) u_edge_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (sel_stb),
        .dly   (dly),
        .pulse (vref_stb)
    );

    assign offset = off_q;

endmodule

// File: rtl/refsw_phase_comp_chk.sv
module refsw_phase_comp_chk
    import refsw_pkg::*;
#(
    parameter int PERIOD      = 16,
    parameter int CLR_LOW_MIN = 30,
    localparam int PW = $clog2(PERIOD),
    localparam int CW = $clog2(CLR_LOW_MIN + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ref_a_stb,
    input logic          ref_b_stb,
    input logic          ref_sel,
    input logic          comp_en,
    input logic          auto_dis,
    input logic          clr_n,
    input logic          vref_stb,
    input logic [PW-1:0] offset,
    input refsw_state_e  st
);

    logic [CW-1:0] low_run;
    logic          clr_due;
    logic          off_mode;
    logic          edge_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              low_run <= '0;
        else if (clr_n)                          low_run <= '0;
        else if (low_run != CW'(CLR_LOW_MIN))    low_run <= low_run + CW'(1);
    end

    assign clr_due  = !clr_n && (low_run >= CW'(CLR_LOW_MIN - 1));
    assign off_mode = !comp_en || auto_dis;
    assign edge_in  = ref_sel ? ref_b_stb : ref_a_stb;

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_due |=> (offset == '0)); // R7

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (off_mode && !clr_due) |=> $stable(offset)); // R5

    AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (off_mode && edge_in) |=> vref_stb); // R5

    AST_UPDATE_ONLY_MEASURE: assert property (@(posedge clk) disable iff (!rst_n)
        ((st != ST_MEASURE) && !clr_due) |=> $stable(offset)); // R3

endmodule

bind refsw_phase_comp refsw_phase_comp_chk #(
    .PERIOD      (PERIOD),
    .CLR_LOW_MIN (CLR_LOW_MIN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_a_stb (ref_a_stb),
    .ref_b_stb (ref_b_stb),
    .ref_sel   (ref_sel),
    .comp_en   (comp_en),
    .auto_dis  (auto_dis),
    .clr_n     (clr_n),
    .vref_stb  (vref_stb),
    .offset    (offset),
    .st        (st)
);

// File: tb/test_refsw_phase_comp.sv
`timescale 1ns/1ps
module test_refsw_phase_comp;

    localparam int P   = 16;
    localparam int MIN = 30;
    localparam int PW  = $clog2(P);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_a_stb = 1'b0, ref_b_stb = 1'b0, ref_sel = 1'b0, fb_stb = 1'b0;
    logic comp_en = 1'b1, auto_dis = 1'b0, clr_n = 1'b1;
    logic vref_stb;
    logic [PW-1:0] offset;

    logic sel_drv = 1'b0, en_drv = 1'b1, dis_drv = 1'b0, clrn_drv = 1'b1;
    logic obs;
    int total = 0, bad = 0, model_off = 0;
    bit done = 0;

    always #5 clk = ~clk;

    refsw_phase_comp #(.PERIOD(P), .CLR_LOW_MIN(MIN)) i_refsw_phase_comp (
        .clk(clk), .rst_n(rst_n), .ref_a_stb(ref_a_stb), .ref_b_stb(ref_b_stb),
        .ref_sel(ref_sel), .fb_stb(fb_stb), .comp_en(comp_en), .auto_dis(auto_dis),
        .clr_n(clr_n), .vref_stb(vref_stb), .offset(offset)
    );

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One clock cycle: sample the result of the previous edge, then apply inputs.
    task automatic tick(input logic a, input logic b, input logic f);
        @(negedge clk);
        obs = vref_stb;
        ref_a_stb = a; ref_b_stb = b; fb_stb = f;
        ref_sel = sel_drv; comp_en = en_drv; auto_dis = dis_drv; clr_n = clrn_drv;
    endtask

    // Edge on the given reference; the pulse must appear exactly dly cycles late.
    task automatic edge_check(input logic on_b, input int dly, input string req);
        int seen;
        if (on_b) tick(1'b0, 1'b1, 1'b0); else tick(1'b1, 1'b0, 1'b0);
        seen = -1;
        for (int k = 0; k <= dly; k++) begin
            tick(1'b0, 1'b0, 1'b0);
            if (obs && seen < 0) seen = k;
        end
        check_eq(req, "strobe delay", seen, dly);
    endtask

    task automatic measure_case(input int d);
        int span;
        logic old_b;
        old_b = sel_drv;
        tick(1'b0, 1'b0, 1'b1);
        sel_drv = ~sel_drv;
        tick(~old_b, old_b, 1'b0);          // R2: strobe on the now-unselected input
        span = (d < 2) ? d + P : d;
        repeat (span - 2) tick(1'b0, 1'b0, 1'b0);
        model_off = (model_off + P - d) % P;
        edge_check(sel_drv, model_off, "R3");
        check_eq("R3", "offset after measurement", int'(offset), model_off);
        edge_check(sel_drv, model_off, "R4");
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick(1'b0, 1'b0, 1'b0);
        check_eq("R1", "vref after reset", int'(obs), 0);
        check_eq("R1", "offset after reset", int'(offset), 0);
        tick(1'b0, 1'b0, 1'b0);

        // Sweep all phase distances, twice, with the offset accumulating.
        for (int r = 0; r < 2; r++)
            for (int d = 0; d < P; d++) measure_case(d);

        // R2: an unselected strobe alone yields no pulse for a full period.
        if (model_off == 0) measure_case(5);
        begin
            int cnt = 0;
            if (sel_drv) tick(1'b1, 1'b0, 1'b0); else tick(1'b0, 1'b1, 1'b0);
            for (int k = 0; k < P + 1; k++) begin tick(1'b0, 1'b0, 1'b0); cnt += int'(obs); end
            check_eq("R2", "pulses from unselected input", cnt, 0);
        end

        // R5: enable low, then auto-disable high.
        for (int m = 0; m < 2; m++) begin
            if (m == 0) en_drv = 1'b0; else dis_drv = 1'b1;
            tick(1'b0, 1'b0, 1'b1);
            sel_drv = ~sel_drv;
            tick(1'b0, 1'b0, 1'b0);
            repeat (4) tick(1'b0, 1'b0, 1'b0);
            edge_check(sel_drv, 0, "R5");
            check_eq("R5", "offset kept while off", int'(offset), model_off);
            en_drv = 1'b1; dis_drv = 1'b0;
            repeat (2) tick(1'b0, 1'b0, 1'b0);
            edge_check(sel_drv, model_off, "R6");
        end

        // R6: measurement abandoned when disabled mid-way.
        tick(1'b0, 1'b0, 1'b1);
        sel_drv = ~sel_drv;
        tick(1'b0, 1'b0, 1'b0);
        repeat (3) tick(1'b0, 1'b0, 1'b0);
        en_drv = 1'b0;
        edge_check(sel_drv, 0, "R6");
        en_drv = 1'b1;
        repeat (2) tick(1'b0, 1'b0, 1'b0);
        edge_check(sel_drv, model_off, "R6");
        check_eq("R6", "offset after abandoned measurement", int'(offset), model_off);

        // R7: one sample short of the threshold, then exactly the threshold.
        clrn_drv = 1'b0;
        repeat (MIN - 1) tick(1'b0, 1'b0, 1'b0);
        clrn_drv = 1'b1;
        repeat (2) tick(1'b0, 1'b0, 1'b0);
        check_eq("R7", "offset after short clear", int'(offset), model_off);
        clrn_drv = 1'b0;
        repeat (MIN) tick(1'b0, 1'b0, 1'b0);
        clrn_drv = 1'b1;
        tick(1'b0, 1'b0, 1'b0);
        check_eq("R7", "offset after full clear", int'(offset), 0);
        model_off = 0;

        // R8: 30th low sample coincides with the measuring edge (d = 13).
        clrn_drv = 1'b0;
        tick(1'b0, 1'b0, 1'b1);
        sel_drv = ~sel_drv;
        tick(1'b0, 1'b0, 1'b0);
        repeat (MIN - 3) tick(1'b0, 1'b0, 1'b0);
        edge_check(sel_drv, 0, "R8");
        check_eq("R8", "offset when clear meets measurement", int'(offset), 0);
        clrn_drv = 1'b1;
        repeat (2) tick(1'b0, 1'b0, 1'b0);
        edge_check(sel_drv, 0, "R8");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule